// File: doc/BRIEF.md
# Indexed configuration register port

This block is a small configuration register file reached through two byte-wide I/O ports. A bus master first writes a register number to the index port. It then reads or writes the chosen register through the data port. Each data access uses up the selected index, so every access needs a fresh index write.

One register, the control register, is always reachable. Bit 4 of the control register is a map-open bit. An extended group of configuration registers can be read or written only while that bit is set. Software therefore opens the map, makes its access and puts the old control value back.

The first extended register drives base-address bits 31:30 from its low two bits. The block presents that value to the rest of the chip as a full 32-bit base address.

Top module: `idxcfg_port`

## Requirements
- R1: `io_claim` is high exactly when a read or write strobe is active and `io_addr` is 0x22 (the index port) or 0x23 (the data port). For any other address, or with no strobe, `io_claim` is low and `io_rdata` is 0x00.
- R2: A data-port read returns the register selected by the most recent index-port write.
- R3: A data-port access consumes the index. A later data-port write with no new index write is ignored, and a later data-port read returns 0xFF.
- R4: The control register (index 0xC3) is readable and writable with all 8 bits, whatever its map-open bit holds.
- R5: While bit 4 of the control register is 0, writes to the extended registers (indices 0xB8 to 0xBB) are ignored and reads of them return 0xFF.
- R6: While bit 4 of the control register is 1, the extended registers store writes and return the stored value on reads.
- R7: `gbase_addr` equals bits 1:0 of extended register 0xB8 shifted left by 30, with bits 29:0 at zero.
- R8: After reset, the control register and every extended register are 0x00, no index is selected (so a data read returns 0xFF) and `gbase_addr` is 0.
- R9: A data access with an index that selects no register reads 0xFF and does not change any register.
- R10: A read of the index port returns the last value written to it.
- R11: When read and write strobes are active together, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while `io_rd` is high |
| io_claim | output | 1 | The block answers this access |
| gbase_addr | output | 32 | Memory-mapped base address |

## Verification
A corrupted index or a stuck valid flag shows up on the very next data-port read: the read returns a wrong register value or 0xFF where stored data was expected. A map-open bit in the wrong state appears as 0xFF reads, or as lost writes, to the extended registers during the same access sequence. A fault in the base register shows on `gbase_addr` one clock after the write. The directed sequences follow the open, access and restore pattern, and they also probe each gate when it is closed.

// File: rtl/idxcfg_pkg.sv
package idxcfg_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int NUM_EXT    = 4;
    localparam int OFF_W      = $clog2(NUM_EXT);
    localparam logic [ADDR_W-1:0] IDX_PORT  = 16'h0022;
    localparam logic [ADDR_W-1:0] DATA_PORT = 16'h0023;
    localparam logic [DATA_W-1:0] CTL_INDEX = 8'hC3;
    localparam logic [DATA_W-1:0] EXT_BASE  = 8'hB8;
    localparam int MAP_BIT    = 4;
    localparam logic [DATA_W-1:0] IDLE_DATA = 8'hFF;

    typedef enum logic [1:0] {
        PORT_NONE  = 2'd0,
        PORT_INDEX = 2'd1,
        PORT_DATA  = 2'd2
    } port_kind_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [DATA_W-1:0] wdata;
    } port_acc_t;

    function automatic logic in_ext(input logic [DATA_W-1:0] idx);
        return ({1'b0, idx} >= {1'b0, EXT_BASE}) &&
               ({1'b0, idx} <  ({1'b0, EXT_BASE} + (DATA_W+1)'(NUM_EXT)));
    endfunction

    function automatic logic [OFF_W-1:0] ext_off(input logic [DATA_W-1:0] idx);
        logic [DATA_W-1:0] d;
        d = idx - EXT_BASE;
        return d[OFF_W-1:0];
    endfunction
endpackage

// File: rtl/idxcfg_decode.sv
module idxcfg_decode
    import idxcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_rd,
    input  logic               io_wr,
    input  logic [DATA_W-1:0]  io_wdata,
    output port_kind_e         kind,
    output port_acc_t          acc
);
    logic strobe;

    always_comb begin
        strobe    = io_rd | io_wr;
        acc.wr    = io_wr;
        acc.rd    = io_rd & ~io_wr;
        acc.wdata = io_wdata;
        if (!strobe)
            kind = PORT_NONE;
        else if (io_addr == IDX_PORT)
            kind = PORT_INDEX;
        else if (io_addr == DATA_PORT)
            kind = PORT_DATA;
        else
            kind = PORT_NONE;
    end

    // R11: a combined strobe never counts as a read
    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_wr) |-> (acc.wr && !acc.rd));
    // R1: claimed kinds only appear under a strobe
    a_r1_need_strobe: assert property (@(posedge clk) disable iff (rst)
        (kind != PORT_NONE) |-> (io_rd || io_wr));
endmodule

// File: rtl/idxcfg_index.sv
module idxcfg_index
    import idxcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  port_kind_e         kind,
    input  port_acc_t          acc,
    output logic [DATA_W-1:0]  index,
    output logic               valid
);
    logic idx_wr, data_use;

    always_comb begin
        idx_wr   = (kind == PORT_INDEX) && acc.wr;
        data_use = (kind == PORT_DATA) && (acc.wr || acc.rd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            index <= '0;
            valid <= 1'b0;
        end else if (idx_wr) begin
            index <= acc.wdata;
            valid <= 1'b1;
        end else if (data_use) begin
            valid <= 1'b0;
        end
    end

    // R3: any data access leaves no index selected
    a_r3_index_consumed: assert property (@(posedge clk) disable iff (rst)
        data_use |=> !valid);
    // R10: the index latch follows index-port writes
    a_r10_index_latch: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> (valid && index == $past(acc.wdata)));
endmodule

// File: rtl/idxcfg_regs.sv
module idxcfg_regs
    import idxcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               data_wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  index,
    input  logic               valid,
    output logic [DATA_W-1:0]  rdata,
    output logic [1:0]         base_hi
);
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] ext_q [NUM_EXT];
    logic              map_open, hit_ctl, sel_ext, hit_ext;
    logic [OFF_W-1:0]  off;

    always_comb begin
        map_open = ctl_q[MAP_BIT];
        hit_ctl  = valid && (index == CTL_INDEX);
        sel_ext  = valid && in_ext(index);
        hit_ext  = sel_ext && map_open;
        off      = ext_off(index);
        if (hit_ctl)
            rdata = ctl_q;
        else if (hit_ext)
            rdata = ext_q[off];
        else
            rdata = IDLE_DATA;
        base_hi = ext_q[0][1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (data_wr && hit_ctl)
            ctl_q <= wdata;
    end

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
        logic we;
        assign we = data_wr && hit_ext && (off == OFF_W'(g));
        always_ff @(posedge clk) begin
            if (rst)
                ext_q[g] <= '0;
            else if (we)
                ext_q[g] <= wdata;
        end
        // R5: a closed map blocks every extended write
        a_r5_closed_hold: assert property (@(posedge clk) disable iff (rst)
            (data_wr && sel_ext && !map_open) |=> $stable(ext_q[g]));
        // R8: reset clears every extended register
        a_r8_ext_reset: assert property (@(posedge clk)
            $past(rst) |-> (ext_q[g] == '0));
    end

    // R8: reset closes the map
    a_r8_ctl_reset: assert property (@(posedge clk)
        $past(rst) |-> (ctl_q == '0));
    // R4: control writes land regardless of map state
    a_r4_ctl_write: assert property (@(posedge clk) disable iff (rst)
        (data_wr && hit_ctl) |=> (ctl_q == $past(wdata)));
endmodule

// File: rtl/idxcfg_port.sv
module idxcfg_port
    import idxcfg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [15:0]  io_addr,
    input  logic         io_rd,
    input  logic         io_wr,
    input  logic [7:0]   io_wdata,
    output logic [7:0]   io_rdata,
    output logic         io_claim,
    output logic [31:0]  gbase_addr
);
    port_kind_e        kind;
    port_acc_t         acc;
    logic [DATA_W-1:0] index, reg_rdata;
    logic              valid;
    logic [1:0]        base_hi;

    idxcfg_decode u_dec (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .kind(kind), .acc(acc)
    );

    idxcfg_index u_idx (
        .clk(clk), .rst(rst), .kind(kind), .acc(acc),
        .index(index), .valid(valid)
    );

    idxcfg_regs u_regs (
        .clk(clk), .rst(rst),
        .data_wr(kind == PORT_DATA && acc.wr), .wdata(acc.wdata),
        .index(index), .valid(valid), .rdata(reg_rdata), .base_hi(base_hi)
    );

    always_comb begin
        io_claim   = (kind != PORT_NONE);
        gbase_addr = {base_hi, 30'b0};
        case (kind)
            PORT_INDEX: io_rdata = index;
            PORT_DATA:  io_rdata = reg_rdata;
            default:    io_rdata = '0;
        endcase
    end

    // R7: base register write shows on the base output next cycle
    a_r7_base_follow: assert property (@(posedge clk) disable iff (rst)
        (kind == PORT_DATA && acc.wr && valid && index == EXT_BASE &&
         reg_rdata != IDLE_DATA && base_hi == reg_rdata[1:0])
        |=> (gbase_addr[31:30] == $past(acc.wdata[1:0])));
    // R1: unclaimed cycles drive zero data
    a_r1_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !io_claim |-> (io_rdata == 8'h00));
endmodule

// File: tb/idxcfg_port_test.sv
module idxcfg_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_claim;
    logic [31:0] gbase_addr;
    int checks = 0, errors = 0;
    logic [7:0] rv;

    idxcfg_port uut (.*);

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic cl);
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        #5 d = io_rdata; cl = io_claim;
        @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [7:0] d);
        logic cl;
        wr(16'h22, idx);
        rd(16'h23, d, cl);
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
        wr(16'h22, idx);
        wr(16'h23, d);
    endtask

    task automatic t_reset;
        logic cl;
        rd(16'h23, rv, cl);
        check("R8 no index after reset", rv, 8'hFF);
        check("R8 gbase reset", gbase_addr, 32'h0);
        rd_reg(8'hC3, rv);
        check("R8 ctl reset", rv, 8'h00);
    endtask

    task automatic t_decode;
        logic cl;
        rd(16'h0024, rv, cl);
        check("R1 other addr claim", cl, 1'b0);
        check("R1 other addr data", rv, 8'h00);
        rd(16'h0122, rv, cl);
        check("R1 high addr bits", cl, 1'b0);
        wr(16'h22, 8'h5A);
        rd(16'h22, rv, cl);
        check("R1 index claim", cl, 1'b1);
        check("R10 index readback", rv, 8'h5A);
    endtask

    task automatic t_ctl_and_consume;
        logic cl;
        wr_reg(8'hC3, 8'hA5);
        rd_reg(8'hC3, rv);
        check("R4 ctl full byte", rv, 8'hA5);
        rd(16'h23, rv, cl);
        check("R3 second read", rv, 8'hFF);
        check("R1 data claim", cl, 1'b1);
        wr(16'h23, 8'h11);
        rd_reg(8'hC3, rv);
        check("R3 second write ignored", rv, 8'hA5);
        wr_reg(8'hC3, 8'h00);
    endtask

    task automatic t_gate;
        wr_reg(8'hB9, 8'h77);
        rd_reg(8'hB9, rv);
        check("R5 closed read", rv, 8'hFF);
        wr_reg(8'hC3, 8'h10);
        rd_reg(8'hB9, rv);
        check("R5 closed write dropped", rv, 8'h00);
        wr_reg(8'hB9, 8'h77);
        wr_reg(8'hBB, 8'h3C);
        rd_reg(8'hB9, rv);
        check("R6 open readback B9", rv, 8'h77);
        rd_reg(8'hBB, rv);
        check("R6 open readback BB", rv, 8'h3C);
        rd_reg(8'hC3, rv);
        check("R4 ctl with map open", rv, 8'h10);
        wr_reg(8'hC3, 8'h00);
        rd_reg(8'hB9, rv);
        check("R5 closed again", rv, 8'hFF);
    endtask

    task automatic t_base;
        logic [7:0] old;
        rd_reg(8'hC3, old);
        wr_reg(8'hC3, old | 8'h10);
        wr_reg(8'hB8, 8'hFE);
        check("R7 base bits 10", gbase_addr, 32'h8000_0000);
        wr_reg(8'hB8, 8'h03);
        check("R7 base bits 11", gbase_addr, 32'hC000_0000);
        wr_reg(8'hC3, old);
        wr_reg(8'hB8, 8'h01);
        check("R7 closed keeps base", gbase_addr, 32'hC000_0000);
    endtask

    task automatic t_unmapped;
        wr_reg(8'h40, 8'h99);
        rd_reg(8'h40, rv);
        check("R9 unmapped read", rv, 8'hFF);
        rd_reg(8'hC3, rv);
        check("R9 ctl untouched", rv, 8'h00);
        rd_reg(8'hB7, rv);
        check("R2 below ext range", rv, 8'hFF);
    endtask

    task automatic t_both;
        wr(16'h22, 8'hC3);
        @(negedge clk); io_addr = 16'h23; io_wdata = 8'h2B; io_wr = 1'b1; io_rd = 1'b1;
        @(negedge clk); io_wr = 1'b0; io_rd = 1'b0;
        rd_reg(8'hC3, rv);
        check("R11 combined strobe writes", rv, 8'h2B);
        wr_reg(8'hC3, 8'h00);
        rd_reg(8'hC3, rv);
        check("R2 read after reselect", rv, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_ctl_and_consume();
        t_gate();
        t_base();
        t_unmapped();
        t_both();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule